// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a small 8-bit controller core to external code and data memories over a bus with few pins. The core hands over one request at a time: a 16-bit address, a kind (code fetch, data read or data write) and, for a write, one data byte. The block runs a fixed bus cycle of one machine cycle (twelve clocks by default). During that cycle the low address byte and the data byte share one 8-bit port, and a second 8-bit port holds the high address byte.

An address latch strobe marks the phase in which the shared port carries the low address. After that phase one active-low strobe moves the data: program-store for code fetches, and read or write for data accesses. An enable input for internal code chooses where fetches go. When it is low, every fetch uses the bus. When it is high, fetches below the internal code size (4 KB) are served on chip and leave the bus idle. A one-clock completion pulse ends each request. Read data is captured from the shared port on the last clock of the strobe.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, req_ready is 1, done, fetch_internal, ale and ad_oe are 0, pstore_n, rd_n and wr_n are 1, and ad_out and hi_addr are 0.
- R2: In an external cycle, ale is high in phases 0 to 2 (phase 0 is the first clock after acceptance). ad_out drives the low address byte with ad_oe high in phases 0 to 3. hi_addr shows the high address byte in all 12 phases.
- R3: ale is never high while any of pstore_n, rd_n or wr_n is low. A strobe falls only after ale has been low for at least one full clock.
- R4: An external fetch (req_kind 0) holds pstore_n low in phases 4 to 10 only, and rd_n and wr_n stay high.
- R5: With int_code_en low, fetches at every address, including 0x0000 to 0x0FFF, use the external bus.
- R6: With int_code_en high, a fetch below 0x1000 drives no strobe and no ale, and leaves ad_oe at 0 and hi_addr at 0. It still takes 12 clocks, and fetch_internal is high together with done. Fetches at 0x1000 and above are external.
- R7: An external read (req_kind 1) holds rd_n low in phases 4 to 10 and releases the port (ad_oe 0) in phases 4 to 11. rdata then equals ad_in as sampled in phase 10.
- R8: A write (req_kind 2) holds wr_n low in phases 4 to 10. The write byte is driven on ad_out with ad_oe high from phase 4 up to and including phase 11, one clock after wr_n rises.
- R9: done is a one-clock pulse in phase 11. req_ready is low in phases 0 to 11 and high again on the next clock. A request presented while busy is ignored.
- R10: At most one of pstore_n, rd_n and wr_n is low at any time.
- R11: req_kind 3 is not a valid kind. Such a request is not accepted: req_ready stays 1 and no done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| int_code_en | input | 1 | 1: fetches below 4 KB are served internally |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 invalid |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Idle; a request is accepted on this clock |
| done | output | 1 | End-of-cycle pulse |
| fetch_internal | output | 1 | With done: fetch was served internally |
| rdata | output | 8 | Captured read or fetch byte |
| ad_out | output | 8 | Shared port, outgoing value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port, incoming value |
| hi_addr | output | 8 | High address byte port |
| ale | output | 1 | Address latch strobe, active high |
| pstore_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The hardest case to reach is a request that arrives in the middle of a running bus cycle. The controller must leave the cycle in progress untouched and must not start a second one afterwards. The bench raises a write request in phase 5 of chosen cycles and withdraws it one clock later. It then checks every phase of the ongoing cycle and the idle state that follows. The bench also sweeps each kind against addresses on both sides of the 4 KB boundary, with the internal-code enable set both ways.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int XB_ADDR_W = 16;
    localparam int XB_DATA_W = 8;
    localparam int XB_HALF_W = XB_ADDR_W - XB_DATA_W;

    typedef enum logic [1:0] {
        XK_FETCH = 2'd0,
        XK_READ  = 2'd1,
        XK_WRITE = 2'd2,
        XK_BAD   = 2'd3
    } xkind_e;

    typedef struct packed {
        xkind_e                 kind;
        logic [XB_ADDR_W-1:0]   addr;
        logic [XB_DATA_W-1:0]   wdata;
        logic                   ext;
    } xreq_t;

    typedef struct packed {
        logic ale;
        logic ps_n;
        logic rd_n;
        logic wr_n;
        logic oe;
        logic done;
        logic cap;
    } xctl_t;

    function automatic logic kind_valid(input xkind_e k);
        return k != XK_BAD;
    endfunction
endpackage

// File: rtl/xbus_route.sv
module xbus_route
    import xbus_pkg::*;
#(
    parameter int INT_CODE_BYTES = 4096
) (
    input  xkind_e               kind,
    input  logic [XB_ADDR_W-1:0] addr,
    input  logic                 int_code_en,
    output logic                 ext
);
    localparam logic [XB_ADDR_W:0] BOUND = (XB_ADDR_W+1)'(INT_CODE_BYTES);

    always_comb begin
        if (kind != XK_FETCH)
            ext = 1'b1;
        else if (!int_code_en)
            ext = 1'b1;
        else
            ext = ({1'b0, addr} >= BOUND);
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int MC_CLOCKS = 12,
    localparam int PH_W = $clog2(MC_CLOCKS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  xreq_t           req_in,
    output logic            busy,
    output logic [PH_W-1:0] phase,
    output xreq_t           cur
);
    localparam logic [PH_W-1:0] LAST_P = PH_W'(MC_CLOCKS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= '0;
            cur   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                phase <= '0;
                cur   <= req_in;
            end
        end else if (phase == LAST_P) begin
            busy  <= 1'b0;
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
    import xbus_pkg::*;
#(
    parameter int MC_CLOCKS = 12,
    localparam int PH_W = $clog2(MC_CLOCKS)
) (
    input  logic                 busy,
    input  logic [PH_W-1:0]      phase,
    input  xreq_t                cur,
    output xctl_t                ctl,
    output logic [XB_DATA_W-1:0] ad_out,
    output logic [XB_HALF_W-1:0] hi_addr
);
    localparam int ALE_LEN = MC_CLOCKS / 4;
    localparam logic [PH_W-1:0] ALE_END_P = PH_W'(ALE_LEN);
    localparam logic [PH_W-1:0] STB_BEG_P = PH_W'(ALE_LEN + 1);
    localparam logic [PH_W-1:0] STB_END_P = PH_W'(MC_CLOCKS - 1);
    localparam logic [PH_W-1:0] CAP_P     = PH_W'(MC_CLOCKS - 2);

    logic ext_act, in_stb, addr_ph;

    always_comb begin
        ext_act = busy && cur.ext;
        addr_ph = phase < STB_BEG_P;
        in_stb  = ext_act && (phase >= STB_BEG_P) && (phase < STB_END_P);

        ctl.ale  = ext_act && (phase < ALE_END_P);
        ctl.ps_n = !(in_stb && cur.kind == XK_FETCH);
        ctl.rd_n = !(in_stb && cur.kind == XK_READ);
        ctl.wr_n = !(in_stb && cur.kind == XK_WRITE);
        ctl.oe   = ext_act && (cur.kind == XK_WRITE || addr_ph);
        ctl.done = busy && (phase == STB_END_P);
        ctl.cap  = in_stb && (cur.kind != XK_WRITE) && (phase == CAP_P);

        if (!ext_act)
            ad_out = '0;
        else if (addr_ph)
            ad_out = cur.addr[XB_DATA_W-1:0];
        else if (cur.kind == XK_WRITE)
            ad_out = cur.wdata;
        else
            ad_out = '0;

        hi_addr = ext_act ? cur.addr[XB_ADDR_W-1:XB_DATA_W] : '0;
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int MC_CLOCKS      = 12,
    parameter int INT_CODE_BYTES = 4096
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 int_code_en,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic [XB_ADDR_W-1:0] req_addr,
    input  logic [XB_DATA_W-1:0] req_wdata,
    output logic                 req_ready,
    output logic                 done,
    output logic                 fetch_internal,
    output logic [XB_DATA_W-1:0] rdata,
    output logic [XB_DATA_W-1:0] ad_out,
    output logic                 ad_oe,
    input  logic [XB_DATA_W-1:0] ad_in,
    output logic [XB_HALF_W-1:0] hi_addr,
    output logic                 ale,
    output logic                 pstore_n,
    output logic                 rd_n,
    output logic                 wr_n
);
    localparam int PH_W = $clog2(MC_CLOCKS);

    xkind_e          kind_in;
    logic            ext_in;
    logic            busy;
    logic            start;
    logic [PH_W-1:0] phase;
    xreq_t           req_in;
    xreq_t           cur;
    xctl_t           ctl;

    assign kind_in = xkind_e'(req_kind);

    xbus_route #(.INT_CODE_BYTES(INT_CODE_BYTES)) u_route (
        .kind        (kind_in),
        .addr        (req_addr),
        .int_code_en (int_code_en),
        .ext         (ext_in)
    );

    always_comb begin
        req_in.kind  = kind_in;
        req_in.addr  = req_addr;
        req_in.wdata = req_wdata;
        req_in.ext   = ext_in;
        start        = req_valid && kind_valid(kind_in);
    end

    xbus_seq #(.MC_CLOCKS(MC_CLOCKS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .req_in (req_in),
        .busy   (busy),
        .phase  (phase),
        .cur    (cur)
    );

    xbus_drive #(.MC_CLOCKS(MC_CLOCKS)) u_drive (
        .busy    (busy),
        .phase   (phase),
        .cur     (cur),
        .ctl     (ctl),
        .ad_out  (ad_out),
        .hi_addr (hi_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (ctl.cap)
            rdata <= ad_in;
    end

    always_comb begin
        req_ready      = !busy;
        done           = ctl.done;
        fetch_internal = ctl.done && !cur.ext;
        ad_oe          = ctl.oe;
        ale            = ctl.ale;
        pstore_n       = ctl.ps_n;
        rd_n           = ctl.rd_n;
        wr_n           = ctl.wr_n;
    end
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk (
    input logic       clk,
    input logic       rst,
    input logic       ale,
    input logic       pstore_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       ad_oe,
    input logic [7:0] ad_out,
    input logic       done,
    input logic       req_ready
);
    // R3
    ale_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> (pstore_n && rd_n && wr_n));

    // R3
    ale_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(pstore_n) || $fell(rd_n) || $fell(wr_n)) |-> (!ale && $past(!ale)));

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({~pstore_n, ~rd_n, ~wr_n}) <= 1);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_ready);

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    // R8
    write_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    // R8
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (ad_oe && $stable(ad_out)));
endmodule

bind xbus_ctrl xbus_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ale       (ale),
    .pstore_n  (pstore_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_oe     (ad_oe),
    .ad_out    (ad_out),
    .done      (done),
    .req_ready (req_ready)
);

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        int_code_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic [7:0]  ad_in = 8'h0;
    logic        req_ready, done, fetch_internal, ad_oe, ale, pstore_n, rd_n, wr_n;
    logic [7:0]  rdata, ad_out, hi_addr;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    xbus_ctrl uut (
        .clk(clk), .rst(rst), .int_code_en(int_code_en), .req_valid(req_valid),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .fetch_internal(fetch_internal),
        .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .hi_addr(hi_addr), .ale(ale), .pstore_n(pstore_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    task automatic run_txn(input logic [1:0] kind, input logic [15:0] addr,
                           input logic [7:0] wd, input logic ea, input bit intrude);
        bit ext;
        string tg;
        ext = (kind != 2'd0) || !ea || (addr >= 16'h1000);
        tg = !ext ? "R6" : (kind == 2'd0 ? (ea ? "R4" : "R5") : (kind == 2'd1 ? "R7" : "R8"));
        @(negedge clk);
        int_code_en = ea;
        req_kind = kind; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
        ad_in = mem_val(addr);
        @(negedge clk);
        req_valid = 1'b0;
        for (int p = 0; p < 12; p++) begin
            logic e_ale, e_stb, e_oe, e_done;
            if (p != 0) @(negedge clk);
            if (intrude && p == 5) begin
                req_valid = 1'b1; req_kind = 2'd2; req_addr = 16'hBEEF;
            end
            if (intrude && p == 6) req_valid = 1'b0;
            e_ale  = ext && p < 3;
            e_stb  = ext && p >= 4 && p <= 10;
            e_oe   = ext && (kind == 2'd2 || p < 4);
            e_done = (p == 11);
            chk(ale == e_ale, "R2", ale, e_ale);
            chk(pstore_n == !(e_stb && kind == 2'd0), tg, pstore_n, !(e_stb && kind == 2'd0));
            chk(rd_n == !(e_stb && kind == 2'd1), tg, rd_n, !(e_stb && kind == 2'd1));
            chk(wr_n == !(e_stb && kind == 2'd2), tg, wr_n, !(e_stb && kind == 2'd2));
            chk(ad_oe == e_oe, tg, ad_oe, e_oe);
            chk(!(ale && (!pstore_n || !rd_n || !wr_n)), "R3", {ale, pstore_n, rd_n, wr_n}, 4'b0111);
            chk(((!pstore_n) + (!rd_n) + (!wr_n)) <= 1, "R10", {pstore_n, rd_n, wr_n}, 3'b111);
            if (e_oe && p < 4) chk(ad_out == addr[7:0], "R2", ad_out, addr[7:0]);
            if (e_oe && p >= 4) chk(ad_out == wd, "R8", ad_out, wd);
            chk(hi_addr == (ext ? addr[15:8] : 8'h00), ext ? "R2" : "R6", hi_addr,
                ext ? addr[15:8] : 8'h00);
            chk(done == e_done, "R9", done, e_done);
            chk(req_ready == 1'b0, "R9", req_ready, 0);
            chk(fetch_internal == (e_done && !ext), "R6", fetch_internal, e_done && !ext);
            if (p == 11 && ext && kind != 2'd2)
                chk(rdata == mem_val(addr), "R7", rdata, mem_val(addr));
        end
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, "R9", {req_ready, done}, 2'b10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] his [5] = '{8'h00, 8'h0F, 8'h10, 8'h7F, 8'hFF};
        logic [7:0] los [3] = '{8'h00, 8'hFF, 8'h5A};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !done && !fetch_internal && !ale && !ad_oe, "R1",
            {req_ready, done, fetch_internal, ale, ad_oe}, 5'b10000);
        chk(pstore_n && rd_n && wr_n, "R1", {pstore_n, rd_n, wr_n}, 3'b111);
        chk(ad_out == 8'h00 && hi_addr == 8'h00, "R1", {ad_out, hi_addr}, 16'h0);

        for (int ea = 0; ea < 2; ea++)
            for (int k = 0; k < 3; k++)
                for (int h = 0; h < 5; h++)
                    for (int l = 0; l < 3; l++)
                        run_txn(2'(k), {his[h], los[l]}, 8'(h * 37 + l * 11 + k),
                                1'(ea), (h == 2 && l == 1));

        // R6 boundary edges
        run_txn(2'd0, 16'h0FFF, 8'h00, 1'b1, 1'b0);
        run_txn(2'd0, 16'h1000, 8'h00, 1'b1, 1'b0);
        // R5 all fetches external with enable low
        run_txn(2'd0, 16'h0000, 8'h00, 1'b0, 1'b0);

        // R11 invalid kind is not accepted
        @(negedge clk);
        req_kind = 2'd3; req_addr = 16'h2345; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 13; c++) begin
            chk(req_ready == 1'b1, "R11", req_ready, 1);
            chk(done == 1'b0 && ale == 1'b0, "R11", {done, ale}, 2'b00);
            @(negedge clk);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule